// File: doc/BRIEF.md
# Multi-precision parallel-prefix adder

This block adds two N-bit words and registers the N-bit result together with the carry-out. The carries come from a parallel-prefix network of logarithmic depth. That network is a binary tree that sweeps upward and merges generate/propagate pairs over spans of growing size. A mirrored tree then sweeps back down with halving spans and fills in the prefixes the first tree left incomplete.

The network has no dedicated carry input. Instead it is one position wider than the operands. The extra lowest position sees the incoming carry on both of its operand inputs, so it generates exactly when the carry is set and never propagates. Every operand bit sits one position higher.

A carry flag register keeps the last carry-out. When the add-with-carry select is high, the flag is fed back as the carry-in. This lets a wide number be summed one word per strobe, starting from the least significant word.

Top module: `mpa_adder`

## Requirements
- R1: A synchronous reset clears `sum_q`, `cout_q` and `carry_flag_q` to 0, and it overrides a `in_valid` raised in the same cycle.
- R2: When `in_valid` is high at a rising edge, after that edge `{cout_q, sum_q}` equals `op_a + op_b + cin` as an (N+1)-bit value.
- R3: When `use_carry` is low, cin is 0 regardless of the carry flag.
- R4: When `use_carry` is high, cin is the carry flag left by the previous valid addition, so that word-serial additions reproduce a wide sum.
- R5: While `in_valid` is low, `sum_q`, `cout_q` and `carry_flag_q` keep their values whatever the operand and select inputs do.
- R6: A carry that ripples through every bit (all-ones plus one) gives `sum_q` = 0 and `cout_q` = 1.
- R7: `carry_flag_q` takes the carry-out of each valid addition and changes at no other time except reset.
- R8: N must be a power of two and at least 4; the adder is exact at N = 4 (all operand pairs) and at N = 32.
- R9: The prefix propagate of every network position is 0, because the carry position never propagates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accepts the operands at this edge |
| use_carry | input | 1 | 1: add the carry flag as carry-in; 0: carry-in is 0 |
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| sum_q | output | N | Registered sum |
| cout_q | output | 1 | Registered carry-out |
| carry_flag_q | output | 1 | Carry flag used by the next add-with-carry |

## Verification
Two functions meet in one edge. A valid add-with-carry reads the carry flag as its carry-in, and the same edge overwrites that flag with its own carry-out. The bench provokes this with back-to-back strobes from the vector table and from a four-word chained addition. It judges each word and the final carry against a 128-bit reference sum computed in the bench. A second overlap, reset and a valid strobe in the same edge, is driven directly; the bench checks that the flag is zero and that the following add-with-carry uses no carry.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

   typedef struct packed {
      logic g;
      logic p;
   } gp_t;

   // Merge a higher-order pair with the adjacent lower-order pair.
   function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
      gp_t r;
      r.g = hi.g | (hi.p & lo.g);
      r.p = hi.p & lo.p;
      return r;
   endfunction

   function automatic int flog2(input int v);
      int r;
      r = 0;
      for (int k = 0; k < 30; k++)
         if ((1 << (k + 1)) <= v) r = k + 1;
      return r;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // Widest down-sweep span whose first node (position 3*span) fits.
   function automatic int down_start(input int m);
      int s;
      s = 1;
      for (int k = 0; k < 30; k++)
         if (3 * s * 2 <= m) s = s * 2;
      return s;
   endfunction

endpackage

// File: rtl/mpa_prefix_level.sv
module mpa_prefix_level
   import mpa_pkg::*;
#(
   parameter int M    = 33,
   parameter int SPAN = 2,
   parameter bit DOWN = 1'b0
) (
   input  gp_t [M-1:0] lvl_in,
   output gp_t [M-1:0] lvl_out
);

   for (genvar k = 0; k < M; k++) begin : g_pos
      localparam int  POS  = k + 1;
      localparam bit  NODE = DOWN ? ((POS >= 2 * SPAN) && (POS % (2 * SPAN) == SPAN))
                                  : (POS % SPAN == 0);
      localparam int  LOW  = DOWN ? (k - SPAN) : (k - SPAN / 2);
      if (NODE) begin : g_node
         assign lvl_out[k] = gp_merge(lvl_in[k], lvl_in[LOW]);
      end else begin : g_pass
         assign lvl_out[k] = lvl_in[k];
      end
   end

endmodule

// File: rtl/mpa_prefix_net.sv
module mpa_prefix_net
   import mpa_pkg::*;
#(
   parameter int M = 33
) (
   input  gp_t  [M-1:0] leaf,
   output logic [M-1:0] grp_g,
   output logic [M-1:0] grp_p
);

   localparam int UPL = flog2(M);
   localparam int DST = down_start(M);
   localparam int DNL = flog2(DST) + 1;
   localparam int TOT = UPL + DNL;

   gp_t [M-1:0] stg [0:TOT];

   assign stg[0] = leaf;

   for (genvar lv = 0; lv < UPL; lv++) begin : g_up
      mpa_prefix_level #(.M(M), .SPAN(2 << lv), .DOWN(1'b0)) u_lvl (
         .lvl_in (stg[lv]),
         .lvl_out(stg[lv+1])
      );
   end

   for (genvar lv = 0; lv < DNL; lv++) begin : g_dn
      mpa_prefix_level #(.M(M), .SPAN(DST >> lv), .DOWN(1'b1)) u_lvl (
         .lvl_in (stg[UPL+lv]),
         .lvl_out(stg[UPL+lv+1])
      );
   end

   for (genvar k = 0; k < M; k++) begin : g_out
      assign grp_g[k] = stg[TOT][k].g;
      assign grp_p[k] = stg[TOT][k].p;
   end

endmodule

// File: rtl/mpa_gp_gen.sv
module mpa_gp_gen
   import mpa_pkg::*;
#(
   parameter int N = 32
) (
   input  logic [N-1:0] op_a,
   input  logic [N-1:0] op_b,
   input  logic         cin,
   output gp_t  [N:0]   leaf
);

   // Lowest position carries cin on both inputs: g = cin & cin, p = cin ^ cin.
   assign leaf[0].g = cin & cin;
   assign leaf[0].p = cin ^ cin;

   for (genvar j = 0; j < N; j++) begin : g_bit
      assign leaf[j+1].g = op_a[j] & op_b[j];
      assign leaf[j+1].p = op_a[j] ^ op_b[j];
   end

endmodule

// File: rtl/mpa_adder.sv
module mpa_adder
   import mpa_pkg::*;
#(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic         use_carry,
   input  logic [N-1:0] op_a,
   input  logic [N-1:0] op_b,
   output logic [N-1:0] sum_q,
   output logic         cout_q,
   output logic         carry_flag_q
);

   localparam int M = N + 1;

   if (!is_pow2(N) || (N < 4)) begin : g_bad_width
      $error("mpa_adder: N must be a power of two and at least 4");
   end

   logic         cin;
   gp_t  [N:0]   leaf;
   logic [M-1:0] grp_g;
   logic [M-1:0] grp_p;
   logic [N-1:0] sum_c;
   logic         cout_c;

   assign cin = use_carry & carry_flag_q;

   mpa_gp_gen #(.N(N)) u_gp (
      .op_a(op_a),
      .op_b(op_b),
      .cin (cin),
      .leaf(leaf)
   );

   mpa_prefix_net #(.M(M)) u_net (
      .leaf (leaf),
      .grp_g(grp_g),
      .grp_p(grp_p)
   );

   // Carry into operand bit j is the group generate ending at position j.
   for (genvar j = 0; j < N; j++) begin : g_sum
      assign sum_c[j] = leaf[j+1].p ^ grp_g[j];
   end
   assign cout_c = grp_g[N];

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_q        <= '0;
         cout_q       <= 1'b0;
         carry_flag_q <= 1'b0;
      end else if (in_valid) begin
         sum_q        <= sum_c;
         cout_q       <= cout_c;
         carry_flag_q <= cout_c;
      end
   end

   // R1: reset clears all state, even with a strobe present
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (sum_q == '0) && !cout_q && !carry_flag_q);

   // R2 / R4: registered result is the arithmetic sum including the fed-back carry
   a_r2_sum_exact: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> {cout_q, sum_q} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)}
                                       + {{N{1'b0}}, $past(use_carry & carry_flag_q)}));

   // R3: without the select, the flag never enters the sum
   a_r3_no_carry_in: assert property (@(posedge clk) disable iff (rst)
      in_valid && !use_carry |=> {cout_q, sum_q} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)}));

   // R5 / R7: idle cycles leave every output and the flag untouched
   a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(sum_q) && $stable(cout_q) && $stable(carry_flag_q));

   // R6: full-length propagate wraps to zero with a carry-out
   a_r6_full_ripple: assert property (@(posedge clk) disable iff (rst)
      in_valid && !use_carry && (&op_a) && (op_b == N'(1)) |=> (sum_q == '0) && cout_q);

   // R9: the carry position kills propagate for every prefix
   a_r9_prefix_kill: assert property (@(posedge clk) disable iff (rst)
      grp_p == '0);

endmodule

// File: tb/mpa_adder_tb.sv
module mpa_adder_tb;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         vld = 1'b0, uc = 1'b0;
   logic [W-1:0] a = '0, b = '0;
   logic [W-1:0] sum;
   logic         co, fl;

   logic         vld4 = 1'b0, uc4 = 1'b0;
   logic [3:0]   a4 = '0, b4 = '0;
   logic [3:0]   sum4;
   logic         co4, fl4;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mpa_adder #(.N(W)) u_dut (
      .clk(clk), .rst(rst), .in_valid(vld), .use_carry(uc),
      .op_a(a), .op_b(b), .sum_q(sum), .cout_q(co), .carry_flag_q(fl)
   );

   mpa_adder #(.N(4)) u_dut_w4 (
      .clk(clk), .rst(rst), .in_valid(vld4), .use_carry(uc4),
      .op_a(a4), .op_b(b4), .sum_q(sum4), .cout_q(co4), .carry_flag_q(fl4)
   );

   // {a, b, use_carry, expected sum, expected carry}; applied back to back in order
   localparam logic [97:0] VEC [0:9] = '{
      {32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0},
      {32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1},
      {32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0001, 1'b0},
      {32'h8000_0000, 32'h8000_0000, 1'b1, 32'h0000_0000, 1'b1},
      {32'h1234_5678, 32'h0FED_CBA9, 1'b0, 32'h2222_2221, 1'b0},
      {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFE, 1'b1},
      {32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1},
      {32'h7FFF_FFFF, 32'h0000_0000, 1'b1, 32'h8000_0000, 1'b0},
      {32'hDEAD_BEEF, 32'h2152_4110, 1'b0, 32'hFFFF_FFFF, 1'b0},
      {32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'hFFFF_FFFF, 1'b0}
   };

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h exp %h", req, got, exp);
      end
   endtask

   task automatic op32(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic tuc);
      a = ta; b = tb; uc = tuc; vld = 1'b1;
      @(negedge clk);
      vld = 1'b0;
   endtask

   task automatic op4(input logic [3:0] ta, input logic [3:0] tb, input logic tuc);
      a4 = ta; b4 = tb; uc4 = tuc; vld4 = 1'b1;
      @(negedge clk);
      vld4 = 1'b0;
   endtask

   initial begin
      logic         mflag;
      logic [32:0]  exp33;
      logic [127:0] wa, wb;
      logic [128:0] wref;
      logic [4:0]   exp5;

      repeat (3) @(negedge clk);
      chk("R1 reset sum", 64'(sum), 64'(0));
      chk("R1 reset carry/flag", 64'({co, fl}), 64'(0));
      chk("R1 reset w4", 64'({co4, fl4, sum4}), 64'(0));
      rst = 1'b0;

      // Vector table: back-to-back strobes, flag read and written in the same edge
      for (int i = 0; i < 10; i++) begin
         op32(VEC[i][97:66], VEC[i][65:34], VEC[i][33]);
         chk(VEC[i][33] ? "R2/R4 table sum" : "R2/R3 table sum", 64'(sum), 64'(VEC[i][32:1]));
         chk("R2/R7 table carry", 64'({co, fl}), 64'({VEC[i][0], VEC[i][0]}));
      end

      // R6: ripple through every bit
      op32(32'hFFFF_FFFF, 32'h1, 1'b0);
      chk("R6 all-ones plus one", 64'({co, sum}), 64'({1'b1, 32'h0}));

      // R3: flag is 1 now, select low must ignore it
      op32(32'h0000_0005, 32'h0000_0007, 1'b0);
      chk("R3 flag ignored", 64'({co, sum}), 64'({1'b0, 32'hC}));

      // R5 / R7: idle cycles with busy inputs, then show the flag survived
      op32(32'hFFFF_FFFF, 32'h1, 1'b0);
      a = 32'h3; b = 32'h4; uc = 1'b1;
      repeat (2) @(negedge clk);
      chk("R5 idle sum held", 64'(sum), 64'(0));
      chk("R5/R7 idle carry and flag held", 64'({co, fl}), 64'(2'b11));
      op32(32'h0, 32'h0, 1'b1);
      chk("R4/R7 held flag used", 64'({co, sum}), 64'({1'b0, 32'h1}));

      // R4: four-word chained addition against a 128-bit reference
      wa = 128'hFFFF_FFFF_0000_0001_FFFF_FFFF_8000_0000;
      wb = 128'h0000_0000_FFFF_FFFF_0000_0001_8000_0000;
      wref = {1'b0, wa} + {1'b0, wb};
      for (int w = 0; w < 4; w++) begin
         op32(wa[w*32 +: 32], wb[w*32 +: 32], (w != 0));
         chk("R4 chained word", 64'(sum), 64'(wref[w*32 +: 32]));
      end
      chk("R4 chained final carry", 64'(co), 64'(wref[128]));

      // R2 / R3 / R4: pseudo-random operands with a bench-side carry model
      mflag = fl;
      for (int i = 0; i < 40; i++) begin
         logic [W-1:0] ra, rb;
         logic         ru;
         ra = $urandom(); rb = $urandom(); ru = $urandom_range(0, 1);
         if (i % 8 == 3) ra = '1;
         exp33 = {1'b0, ra} + {1'b0, rb} + 33'(ru & mflag);
         op32(ra, rb, ru);
         chk("R2 random", 64'({co, sum}), 64'(exp33));
         mflag = exp33[32];
      end

      // R1: reset and strobe in the same edge, reset wins
      op32(32'hFFFF_FFFF, 32'h1, 1'b0);
      rst = 1'b1; a = 32'h5; b = 32'h5; uc = 1'b1; vld = 1'b1;
      @(negedge clk);
      rst = 1'b0; vld = 1'b0;
      chk("R1 reset beats strobe", 64'({co, fl, sum}), 64'(0));
      op32(32'h0, 32'h0, 1'b1);
      chk("R1 flag cleared by reset", 64'({co, sum}), 64'(0));

      // R8: exhaustive 4-bit instance, select follows a[0], flag modelled
      mflag = 1'b0;
      for (int x = 0; x < 16; x++) begin
         for (int y = 0; y < 16; y++) begin
            exp5 = 5'(x) + 5'(y) + 5'(x[0] & mflag);
            op4(4'(x), 4'(y), x[0]);
            chk("R8 width 4", 64'({co4, sum4}), 64'(exp5));
            mflag = exp5[4];
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule